// File: doc/BRIEF.md
# Pipelined Burst SRAM With No Read/Write Turnaround

This block is a small synchronous memory that lets a read and a write follow one another on every clock with no idle cycle between them. Each command is taken on a rising edge. The data beat for that command happens on the next accepted edge:

- **Write:** the write data is captured on that edge.
- **Read:** the read data is registered onto the output on that edge.

Because both data beats sit one stage after their commands, the data path never has to change direction in a way that would cost a cycle.

A load cycle supplies an address and an operation. Advance cycles then step a two-bit beat counter, so one address serves a four-beat burst. A strap input picks one of two beat orders:

- linear order, or
- interleaved order.

An active-low clock enable freezes the whole block without deselecting it. Three chip-select inputs decide whether a load cycle selects the device.

Per-lane active-low write selects mask partial writes. Each lane is 9 bits wide, holding 8 data bits and a parity bit. An asynchronous active-low output enable, together with the internal pipeline state, drives a flag that stands in for the tri-state drive of a shared data bus.

Top module: `pipe_burst_sram`

## Requirements
- R1: While reset is high, and after it is released, the output drive flag is low and `rdata` reads zero until a read completes.
- R2: When `clk_en_n` is high on an edge, that edge is ignored. No input is sampled, the pipeline and burst counter do not change, and `rdata` stays stable. The device is not deselected, so a burst resumes on the next accepted edge.
- R3: A load cycle selects the device only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. Any other combination deselects it, and that load performs no memory access.
- R4: A read loaded at accepted edge n places the contents of the addressed word on `rdata` after accepted edge n+1.
- R5: A write loaded at accepted edge n takes `wdata` at accepted edge n+1. Lane k is bits [9k+8:9k], and it is written only if `lane_wr_n[k]`=0 at edge n. The parity bit of a lane follows that lane's select.
- R6: Reads and writes may alternate on every edge. A read loaded right after a write to the same address returns the newly written data.
- R7: `advance`=1 on an accepted edge continues the previous operation type at the next burst beat. Only address bits [1:0] change, they wrap within the four-word block, and the burst keeps wrapping past the fourth beat.
- R8: With `ilv_mode`=1, the low address bits of beat b are the start bits XOR b.
- R9: With `ilv_mode`=0, the low address bits of beat b are the start bits plus b, modulo 4.
- R10: An advance cycle taken while deselected, or after reset, performs no access. A load is needed to start a new one.
- R11: `rdata_drive` is low during a write data beat, while deselected, and in the first cycle after reselection. Otherwise, when read data is present, it follows the inverse of `oe_n` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write (0) or read (1) on a load cycle |
| advance | input | 1 | 1 advances the burst, 0 loads a new command |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| ilv_mode | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data for the pending write beat |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drive | output | 1 | High when the read data would be driven |

## Verification
The assertions assume the following about the inputs:

- All inputs are known once reset is released.
- `oe_n` is steady around the sampling edge.
- `ilv_mode` changes only while no burst is under way.

The bench drives every input at the falling edge and changes the strap only after a deselecting load. It pulses `oe_n` between edges, so the asynchronous path is observed directly. During stalled edges it deliberately presents conflicting commands and inverted write data. It holds a reference word array that it updates only on accepted edges, and it checks every read against that array.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int unsigned BEAT_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic              active;
        op_e               op;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] cnt;
    } burst_t;

    function automatic logic [BEAT_W-1:0] beat_low(
        input logic              ilv,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] cnt
    );
        logic [BEAT_W-1:0] r;
        if (ilv) r = start ^ cnt;
        else     r = start + cnt;
        return r;
    endfunction

endpackage

// File: rtl/psram_cmd.sv
module psram_cmd
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              load,
    input  logic              sel,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ilv,
    output op_e               st_op,
    output logic [ADDR_W-1:0] st_addr,
    output logic [LANES-1:0]  st_bw_n
);
    localparam int unsigned HI_W = ADDR_W - BEAT_W;

    burst_t            burst;
    logic [HI_W-1:0]   blk;
    logic [BEAT_W-1:0] nxt_cnt;
    logic [BEAT_W-1:0] nxt_low;

    always_comb begin
        nxt_cnt = burst.cnt + 1'b1;
        nxt_low = beat_low(ilv, burst.start, nxt_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            burst   <= '0;
            blk     <= '0;
            st_op   <= OP_NONE;
            st_addr <= '0;
            st_bw_n <= '1;
        end else if (acc) begin
            if (load) begin
                if (sel) begin
                    st_op        <= wr_n ? OP_READ : OP_WRITE;
                    st_addr      <= addr;
                    st_bw_n      <= lane_wr_n;
                    burst.active <= 1'b1;
                    burst.op     <= wr_n ? OP_READ : OP_WRITE;
                    burst.start  <= addr[BEAT_W-1:0];
                    burst.cnt    <= '0;
                    blk          <= addr[ADDR_W-1:BEAT_W];
                end else begin
                    st_op        <= OP_NONE;
                    burst.active <= 1'b0;
                end
            end else if (burst.active) begin
                st_op     <= burst.op;
                st_addr   <= {blk, nxt_low};
                st_bw_n   <= lane_wr_n;
                burst.cnt <= nxt_cnt;
            end else begin
                st_op <= OP_NONE;
            end
        end
    end

endmodule

// File: rtl/psram_store.sv
module psram_store
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned LANES  = 4,
    parameter int unsigned LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc,
    input  op_e                     st_op,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [LANES-1:0]        st_bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rd_vld
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic do_wr;
    logic do_rd;

    always_comb begin
        do_wr = acc && (st_op == OP_WRITE);
        do_rd = acc && (st_op == OP_READ);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (do_wr && !st_bw_n[k]) begin
                mem[st_addr] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[k*LANE_W +: LANE_W] <= '0;
            end else if (do_rd) begin
                rdata[k*LANE_W +: LANE_W] <= mem[st_addr];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      rd_vld <= 1'b0;
        else if (acc) rd_vld <= do_rd;
    end

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
    import psram_pkg::*;
#(
    parameter  int unsigned ADDR_W = 6,
    parameter  int unsigned LANES  = 4,
    parameter  int unsigned LANE_W = 9,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              wr_n,
    input  logic              advance,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ilv_mode,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    logic              acc;
    logic              sel;
    op_e               st_op;
    logic [ADDR_W-1:0] st_addr;
    logic [LANES-1:0]  st_bw_n;
    logic              rd_vld;

    always_comb begin
        acc = !clk_en_n;
        sel = !sel1_n && sel2 && !sel3_n;
    end

    psram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .load      (!advance),
        .sel       (sel),
        .wr_n      (wr_n),
        .lane_wr_n (lane_wr_n),
        .addr      (addr),
        .ilv       (ilv_mode),
        .st_op     (st_op),
        .st_addr   (st_addr),
        .st_bw_n   (st_bw_n)
    );

    psram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .st_op   (st_op),
        .st_addr (st_addr),
        .st_bw_n (st_bw_n),
        .wdata   (wdata),
        .rdata   (rdata),
        .rd_vld  (rd_vld)
    );

    assign rdata_drive = rd_vld && !oe_n;

endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
    parameter int unsigned DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              clk_en_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              wr_n,
    input logic              advance,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_drive
);
    logic acc_load_sel;
    logic acc_load_desel;

    always_comb begin
        acc_load_sel   = !clk_en_n && !advance && (!sel1_n && sel2 && !sel3_n);
        acc_load_desel = !clk_en_n && !advance && !(!sel1_n && sel2 && !sel3_n);
    end

    // R11: the drive flag never rises while the output enable is off
    a_r11_drive_needs_oe: assert property (@(posedge clk) disable iff (rst)
        rdata_drive |-> !oe_n);

    // R2: a stalled edge leaves the read data untouched
    a_r2_stall_holds_data: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> $stable(rdata));

    // R3: a deselecting load yields no driven data on its beat
    a_r3_desel_no_drive: assert property (@(posedge clk) disable iff (rst)
        acc_load_desel ##1 !clk_en_n |=> !rdata_drive);

    // R5: the data beat of a write is never driven
    a_r5_write_beat_quiet: assert property (@(posedge clk) disable iff (rst)
        (acc_load_sel && !wr_n) ##1 !clk_en_n |=> !rdata_drive);

    // R4: a read's data beat drives exactly when output enable is on
    a_r4_read_beat_drives: assert property (@(posedge clk) disable iff (rst)
        (acc_load_sel && wr_n) ##1 !clk_en_n |=> (rdata_drive == !oe_n));

    // R10: advance from a deselected state starts no access
    a_r10_adv_idle: assert property (@(posedge clk) disable iff (rst)
        acc_load_desel ##1 (!clk_en_n && advance) ##1 !clk_en_n |=> !rdata_drive);

endmodule

bind pipe_burst_sram psram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en_n    (clk_en_n),
    .sel1_n      (sel1_n),
    .sel2        (sel2),
    .sel3_n      (sel3_n),
    .wr_n        (wr_n),
    .advance     (advance),
    .oe_n        (oe_n),
    .rdata       (rdata),
    .rdata_drive (rdata_drive)
);

// File: tb/pipe_burst_sram_test.sv
`timescale 1ns/1ps
module pipe_burst_sram_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en_n = 1'b0;
    logic        sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
    logic        wr_n = 1'b1, advance = 1'b0;
    logic [3:0]  lane_wr_n = 4'hF;
    logic [5:0]  addr = '0;
    logic        ilv_mode = 1'b1;
    logic        oe_n = 1'b0;
    logic [35:0] wdata = '0;
    logic [35:0] rdata;
    logic        rdata_drive;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    logic [35:0] refm [64];
    logic [35:0] carry = '0;
    int          pend_op = 0;  // 0 none, 1 read, 2 write
    logic [5:0]  pend_a = '0;
    logic [3:0]  pend_bw = 4'hF;
    bit          b_act = 0;
    int          b_op = 0;
    logic [3:0]  b_hi = '0;
    logic [1:0]  b_start = '0, b_cnt = '0;
    bit          exp_rd = 0;
    logic [35:0] exp_data = '0;

    always #5 clk = ~clk;

    pipe_burst_sram uut (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
        .sel3_n(sel3_n), .wr_n(wr_n), .advance(advance), .lane_wr_n(lane_wr_n),
        .addr(addr), .ilv_mode(ilv_mode), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    function automatic logic [35:0] pat(input int n);
        return (36'(n) * 36'h0_9E37_79B1) ^ 36'h5_A5A5_A5A5;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic tick(input bit en_n, input bit s1n, input bit s2, input bit s3n,
                        input bit wn, input bit adv, input logic [3:0] bw, input logic [5:0] a);
        clk_en_n = en_n; sel1_n = s1n; sel2 = s2; sel3_n = s3n;
        wr_n = wn; advance = adv; lane_wr_n = bw; addr = a;
        wdata = en_n ? ~carry : carry;
        @(posedge clk);
        if (!en_n) begin
            if (pend_op == 2) begin
                for (int k = 0; k < 4; k++)
                    if (!pend_bw[k]) refm[pend_a][k*9 +: 9] = wdata[k*9 +: 9];
            end
            exp_rd = (pend_op == 1);
            if (exp_rd) exp_data = refm[pend_a];
            if (!adv) begin
                if (!s1n && s2 && !s3n) begin
                    pend_op = wn ? 1 : 2; pend_a = a; pend_bw = bw;
                    b_act = 1; b_op = pend_op; b_hi = a[5:2]; b_start = a[1:0]; b_cnt = 0;
                end else begin
                    pend_op = 0; b_act = 0;
                end
            end else if (b_act) begin
                b_cnt = b_cnt + 2'd1;
                pend_op = b_op;
                pend_a = {b_hi, ilv_mode ? (b_start ^ b_cnt) : 2'(b_start + b_cnt)};
                pend_bw = bw;
            end else begin
                pend_op = 0;
            end
        end
        @(negedge clk);
        chk(rdata_drive == (exp_rd && !oe_n), "drive flag", 36'(rdata_drive), 36'(exp_rd && !oe_n));
        if (exp_rd && !oe_n) chk(rdata == exp_data, "read data", rdata, exp_data);
    endtask

    task automatic op_write(input logic [5:0] a, input logic [3:0] bw, input logic [35:0] d);
        tick(0, 0, 1, 0, 0, 0, bw, a); carry = d;
    endtask
    task automatic op_read(input logic [5:0] a);
        tick(0, 0, 1, 0, 1, 0, 4'hF, a);
    endtask
    task automatic op_adv(input logic [3:0] bw, input logic [35:0] d);
        tick(0, 0, 1, 0, 1, 1, bw, 6'd0); carry = d;
    endtask
    task automatic op_desel();
        tick(0, 1, 1, 0, 1, 0, 4'hF, 6'd0);
    endtask
    task automatic op_stall();
        tick(1, 0, 1, 0, 0, 0, 4'h0, 6'd63);
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R1";
        chk(rdata_drive == 1'b0, "drive in reset", 36'(rdata_drive), 36'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(rdata_drive == 1'b0, "drive after reset", 36'(rdata_drive), 36'd0);
        chk(rdata == 36'd0, "data after reset", rdata, 36'd0);

        // Fill memory with back-to-back full writes, then read all
        cur_req = "R5";
        for (int a = 0; a < 64; a++) op_write(6'(a), 4'h0, pat(a));
        op_desel();
        cur_req = "R4";
        for (int a = 0; a < 64; a++) op_read(6'(a));
        op_desel();

        // Alternating writes and reads to the same address
        cur_req = "R6";
        for (int a = 0; a < 16; a++) begin
            op_write(6'(a), 4'h0, pat(a + 100));
            op_read(6'(a));
            op_read(6'(a ^ 1));
        end
        op_desel();

        // Every partial lane mask
        cur_req = "R5";
        for (int m = 0; m < 16; m++) begin
            op_write(6'd40, 4'(m), pat(m + 200));
            op_read(6'd40);
        end
        op_desel();

        // Bursts in both orders, all start offsets, with wrap past four beats
        for (int md = 0; md < 2; md++) begin
            ilv_mode = md[0];
            for (int s = 0; s < 4; s++) begin
                cur_req = "R7";
                op_write({4'(8 + md * 4 + s), 2'(s)}, 4'h0, pat(300 + md * 40 + s * 8));
                for (int b = 1; b < 4; b++) op_adv(4'h0, pat(300 + md * 40 + s * 8 + b));
                cur_req = md ? "R8" : "R9";
                op_read({4'(8 + md * 4 + s), 2'(s)});
                for (int b = 0; b < 5; b++) op_adv(4'hF, '0);
                op_desel();
            end
        end

        // Stalls inside write and read bursts with conflicting inputs
        cur_req = "R2";
        ilv_mode = 1'b0;
        op_write(6'd22, 4'h0, pat(500));
        op_stall(); op_stall();
        op_adv(4'h0, pat(501));
        op_stall();
        op_adv(4'h5, pat(502));
        op_adv(4'h0, pat(503));
        op_stall();
        op_read(6'd22);
        op_stall(); op_stall(); op_stall();
        op_adv(4'hF, '0);
        op_stall(); op_stall();
        op_adv(4'hF, '0);
        op_adv(4'hF, '0);
        op_stall();
        op_desel();

        // Every deselecting select combination on a write load
        cur_req = "R3";
        for (int c = 0; c < 8; c++) begin
            if (c != 2) begin
                tick(0, c[2], c[1], c[0], 0, 0, 4'h0, 6'd50);
                carry = ~refm[50];
                op_read(6'd50);
                op_desel();
            end
        end

        // Advances while deselected
        cur_req = "R10";
        op_desel();
        tick(0, 0, 1, 0, 0, 1, 4'h0, 6'd0); carry = 36'hF_0F0F_0F0F;
        tick(0, 0, 1, 0, 0, 1, 4'h0, 6'd0); carry = 36'hA_BCDE_F012;
        tick(0, 0, 1, 0, 1, 1, 4'hF, 6'd0);
        for (int a = 0; a < 64; a++) op_read(6'(a));

        // Asynchronous output enable while read data is present
        cur_req = "R11";
        op_read(6'd7);
        op_desel();
        oe_n = 1'b1; #1;
        chk(rdata_drive == 1'b0, "oe off async", 36'(rdata_drive), 36'd0);
        oe_n = 1'b0; #1;
        chk(rdata_drive == 1'b1, "oe on async", 36'(rdata_drive), 36'd1);
        @(negedge clk);
        oe_n = 1'b1;
        for (int a = 0; a < 4; a++) op_read(6'(a));
        oe_n = 1'b0;
        op_write(6'd9, 4'h0, pat(900));
        op_read(6'd9);
        op_desel();
        op_read(6'd9);
        op_desel();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule